// File: doc/BRIEF.md
# Board Part-Number String Reader

This block is a sequencer that fetches a board assembly number from non-volatile memory through a word-wide read port and delivers it as a stream of ASCII bytes. After a start pulse it reads two header words at fixed addresses. The first header word decides between two encodings. If it holds the guard value, the second word is a pointer to a length-prefixed character string. Otherwise the two header words hold the number directly as packed hex nibbles.

In the packed case the block converts each nibble to an ASCII hex character and inserts a dash and a placeholder character, for a fixed-size 11-byte result. In the pointer case the block reads the length word, checks it, and then streams two characters from each following word. Both encodings end with a null byte. The caller gives the size of its destination buffer, and the block refuses with a no-space status when the result would not fit. Every run ends with a one-cycle done pulse that carries a status code.

Top module: `pn_string_reader`

## Requirements
- R1: After `start`, the block reads word address `HDR_A` (default 0x08) and then `HDR_B` (default 0x09). `rd_req` stays high with `rd_addr` stable until `rd_valid` or `rd_err` is seen.
- R2: A read that ends with `rd_err` stops the run. No further byte is emitted, and `done` pulses with `status` = 1 (read error). Bytes already emitted remain emitted.
- R3: When header word A is not `GUARD` (default 0xFAFA), 11 bytes are emitted in this order: the four nibbles of word A from the most significant down, the upper two nibbles of word B, `-` (0x2D), the placeholder `0` (0x30), the lower two nibbles of word B, and 0x00.
- R4: In the packed format, a nibble value 0..9 becomes 0x30..0x39 and a value 10..15 becomes 0x41..0x46 (upper-case letters).
- R5: In the packed format, `buf_limit` below 11 ends the run with `status` = 3 (no space) and no bytes. A value of exactly 11 is accepted.
- R6: When header word A equals `GUARD`, word B is used as an address and the length word L is read there. L = 0 or L = 0xFFFF ends the run with `status` = 2 (invalid section) and no bytes.
- R7: In the pointer format, `buf_limit` < 2·L−1 ends the run with `status` = 3 and no bytes. Equality is accepted.
- R8: In the pointer format, the L−1 words at B+1, B+2, … are read in order. For each word the high byte is emitted and then the low byte, followed by a final 0x00. In total 2·L−1 bytes are emitted, so L = 1 gives the null byte only.
- R9: A byte is transferred when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` stays unchanged.
- R10: `done` is a one-cycle pulse. It comes one cycle after the final byte is accepted, with `status` = 0 on success. A `start` pulse seen while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| buf_limit | input | LIMIT_W | Destination buffer size in bytes |
| rd_req | output | 1 | Word read request, held until answered |
| rd_addr | output | ADDR_W | Word address of the request |
| rd_valid | input | 1 | Read completed, `rd_data` valid |
| rd_err | input | 1 | Read failed |
| rd_data | input | 16 | Returned word |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_byte | output | 8 | ASCII output byte |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 ok, 1 read error, 2 invalid section, 3 no space |

## Verification
A read answer changes the request address on the next cycle. An accepted byte is followed by the next byte one cycle later. The done pulse arrives one cycle after the final byte is accepted, or one cycle after the failing read or the failed length check. The bench drives all inputs and samples all outputs on the falling edge, so each response is observed half a cycle after the edge that produced it. Byte acceptance is recorded with the same ready value that the next rising edge uses. The memory model answers each request two cycles after it appears and toggles ready to create back-pressure. Status and byte streams are therefore compared only after the done pulse has been seen.

// File: rtl/pn_pkg.sv
package pn_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RDA, S_RDB, S_RDLEN, S_RDW, S_HI, S_LO, S_NUL, S_PACK, S_FIN
    } pn_state_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_RDERR   = 2'd1,
        ST_BADSEC  = 2'd2,
        ST_NOSPACE = 2'd3
    } pn_status_e;

    localparam int WORD_W   = 16;
    localparam int PACK_LEN = 11;

    typedef struct packed {
        pn_state_e   state;
        pn_status_e  status;
        logic [15:0] wa;
        logic [15:0] wb;
        logic [15:0] word;
        logic [15:0] ptr;
        logic [15:0] cnt;
        logic [3:0]  idx;
    } pn_regs_t;
endpackage

// File: rtl/pn_hex_ascii.sv
module pn_hex_ascii (
    input  logic [3:0] nib,
    output logic [7:0] ascii
);
    always_comb begin
        if (nib < 4'd10) ascii = 8'h30 + {4'd0, nib};
        else             ascii = 8'h37 + {4'd0, nib};
    end
endmodule

// File: rtl/pn_pack_fmt.sv
module pn_pack_fmt (
    input  logic [15:0] wa,
    input  logic [15:0] wb,
    input  logic [3:0]  idx,
    output logic [7:0]  byte_o
);
    logic [3:0] nib;
    logic [7:0] hex;

    pn_hex_ascii u_hex (.nib(nib), .ascii(hex));

    always_comb begin
        case (idx)
            4'd0:    nib = wa[15:12];
            4'd1:    nib = wa[11:8];
            4'd2:    nib = wa[7:4];
            4'd3:    nib = wa[3:0];
            4'd4:    nib = wb[15:12];
            4'd5:    nib = wb[11:8];
            4'd8:    nib = wb[7:4];
            4'd9:    nib = wb[3:0];
            default: nib = 4'd0;   // placeholder slot converts a zero nibble
        endcase
        case (idx)
            4'd6:    byte_o = 8'h2D;
            4'd10:   byte_o = 8'h00;
            default: byte_o = hex;
        endcase
    end
endmodule

// File: rtl/pn_string_reader.sv
module pn_string_reader
    import pn_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          LIMIT_W = 16,
    parameter logic [15:0] GUARD   = 16'hFAFA,
    parameter logic [15:0] HDR_A   = 16'h0008,
    parameter logic [15:0] HDR_B   = 16'h0009
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LIMIT_W-1:0] buf_limit,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_valid,
    input  logic               rd_err,
    input  logic [15:0]        rd_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_byte,
    output logic               done,
    output logic [1:0]         status
);
    localparam int CMP_W = (LIMIT_W > WORD_W ? LIMIT_W : WORD_W) + 2;

    pn_regs_t r_q, r_d;
    logic [7:0]       pack_byte;
    logic [CMP_W-1:0] need_bytes, have_bytes;

    pn_pack_fmt u_pack (.wa(r_q.wa), .wb(r_q.wb), .idx(r_q.idx), .byte_o(pack_byte));

    assign need_bytes = (CMP_W'(rd_data) << 1) - CMP_W'(1);
    assign have_bytes = CMP_W'(buf_limit);

    // outputs decoded from registered state
    always_comb begin
        rd_req  = 1'b0;
        rd_addr = '0;
        case (r_q.state)
            S_RDA:   begin rd_req = 1'b1; rd_addr = ADDR_W'(HDR_A); end
            S_RDB:   begin rd_req = 1'b1; rd_addr = ADDR_W'(HDR_B); end
            S_RDLEN: begin rd_req = 1'b1; rd_addr = ADDR_W'(r_q.wb); end
            S_RDW:   begin rd_req = 1'b1; rd_addr = ADDR_W'(r_q.ptr); end
            default: ;
        endcase
        out_valid = (r_q.state == S_HI) || (r_q.state == S_LO) ||
                    (r_q.state == S_NUL) || (r_q.state == S_PACK);
        case (r_q.state)
            S_HI:    out_byte = r_q.word[15:8];
            S_LO:    out_byte = r_q.word[7:0];
            S_PACK:  out_byte = pack_byte;
            default: out_byte = 8'h00;
        endcase
        done   = (r_q.state == S_FIN);
        status = r_q.status;
    end

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            S_IDLE: if (start) r_d.state = S_RDA;
            S_RDA: begin
                if (rd_err) begin
                    r_d.status = ST_RDERR; r_d.state = S_FIN;
                end else if (rd_valid) begin
                    r_d.wa = rd_data; r_d.state = S_RDB;
                end
            end
            S_RDB: begin
                if (rd_err) begin
                    r_d.status = ST_RDERR; r_d.state = S_FIN;
                end else if (rd_valid) begin
                    r_d.wb = rd_data;
                    if (r_q.wa != GUARD) begin
                        if (have_bytes < CMP_W'(PACK_LEN)) begin
                            r_d.status = ST_NOSPACE; r_d.state = S_FIN;
                        end else begin
                            r_d.idx = '0; r_d.state = S_PACK;
                        end
                    end else begin
                        r_d.state = S_RDLEN;
                    end
                end
            end
            S_RDLEN: begin
                if (rd_err) begin
                    r_d.status = ST_RDERR; r_d.state = S_FIN;
                end else if (rd_valid) begin
                    if (rd_data == 16'h0000 || rd_data == 16'hFFFF) begin
                        r_d.status = ST_BADSEC; r_d.state = S_FIN;
                    end else if (have_bytes < need_bytes) begin
                        r_d.status = ST_NOSPACE; r_d.state = S_FIN;
                    end else begin
                        r_d.cnt   = rd_data - 16'd1;
                        r_d.ptr   = r_q.wb + 16'd1;
                        r_d.state = (rd_data == 16'd1) ? S_NUL : S_RDW;
                    end
                end
            end
            S_RDW: begin
                if (rd_err) begin
                    r_d.status = ST_RDERR; r_d.state = S_FIN;
                end else if (rd_valid) begin
                    r_d.word = rd_data; r_d.state = S_HI;
                end
            end
            S_HI: if (out_ready) r_d.state = S_LO;
            S_LO: if (out_ready) begin
                r_d.ptr   = r_q.ptr + 16'd1;
                r_d.cnt   = r_q.cnt - 16'd1;
                r_d.state = (r_q.cnt == 16'd1) ? S_NUL : S_RDW;
            end
            S_NUL: if (out_ready) begin
                r_d.status = ST_OK; r_d.state = S_FIN;
            end
            S_PACK: if (out_ready) begin
                if (r_q.idx == 4'(PACK_LEN - 1)) begin
                    r_d.status = ST_OK; r_d.state = S_FIN;
                end else begin
                    r_d.idx = r_q.idx + 4'd1;
                end
            end
            S_FIN:   r_d.state = S_IDLE;
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= S_IDLE;
            r_q.status <= ST_OK;
        end else begin
            r_q <= r_d;
        end
    end

    // R1: a pending request keeps its address until answered
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid && !rd_err |=> rd_req && $stable(rd_addr));

    // R2: a failed read ends the run with the read-error code
    p_err_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_err |=> done && status == 2'd1 && !out_valid);

    // R9: a stalled byte is held
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a zero or all-ones length word is rejected
    p_badlen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_valid && !rd_err && r_q.state == S_RDLEN &&
        (rd_data == 16'h0000 || rd_data == 16'hFFFF) |=> done && status == 2'd2);
endmodule

// File: tb/sim_pn_string_reader.sv
`timescale 1ns/1ps
module sim_pn_string_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] buf_limit = 16'd64;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic        rd_err = 1'b0;
    logic [15:0] rd_data = 16'h0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;
    logic        done;
    logic [1:0]  status;

    always #2.5 clk = ~clk;

    pn_string_reader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_limit(buf_limit),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_err(rd_err),
        .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte), .done(done), .status(status)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [15:0] mem [0:255];
    logic        err_en = 1'b0;
    logic [15:0] err_addr = 16'h0;
    int          lat_cnt = 0;
    logic        bp_mode = 1'b0;
    logic [7:0]  got [$];
    logic [15:0] addrs [$];
    int          done_cnt = 0;
    logic [1:0]  last_st = 2'd0;
    logic        hold_pend = 1'b0;
    logic [7:0]  hold_byte = 8'h0;
    int          hold_viol = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // memory model, consumer and monitors, all on the falling edge
    always @(negedge clk) begin
        logic nr;
        cyc++;
        if (rd_valid || rd_err) begin
            rd_valid <= 1'b0; rd_err <= 1'b0; lat_cnt = 0;
        end else if (rd_req) begin
            lat_cnt++;
            if (lat_cnt == 2) begin
                addrs.push_back(rd_addr);
                if (err_en && rd_addr == err_addr) rd_err <= 1'b1;
                else begin rd_valid <= 1'b1; rd_data <= mem[rd_addr[7:0]]; end
            end
        end
        if (hold_pend && (!out_valid || out_byte != hold_byte)) hold_viol++;
        nr = bp_mode ? ~out_ready : 1'b1;
        out_ready <= nr;
        if (out_valid && nr) got.push_back(out_byte);
        hold_pend = out_valid && !nr;
        hold_byte = out_byte;
        if (done) begin done_cnt++; last_st = status; end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run(input logic [15:0] lim, input bit poke_start);
        got.delete(); addrs.delete(); done_cnt = 0;
        buf_limit = lim;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 3000 && done_cnt == 0; i++) begin
            @(negedge clk);
            if (poke_start && i == 12) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_bytes(input string tag, input logic [7:0] exp [$]);
        chk(got.size() == exp.size(), tag, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            chk(got[i] == exp[i], tag, got[i], exp[i]);
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        chk(rd_req == 1'b0, "R1 reset rd_req", rd_req, 0);
    endtask

    task automatic t_pack_a;
        logic [7:0] e [$];
        mem[8] = 16'h1A2F; mem[9] = 16'h3CB9;
        bp_mode = 1'b1;
        run(16'd11, 1'b1);
        e = '{"1","A","2","F","3","C","-","0","B","9",8'h00};
        cmp_bytes("R3 R4 R9 packed stream", e);
        chk(addrs.size() == 2 && addrs[0] == 16'h8 && addrs[1] == 16'h9, "R1 header order",
            addrs.size() > 0 ? addrs[0] : -1, 8);
        chk(last_st == 2'd0, "R10 ok status", last_st, 0);
        chk(done_cnt == 1, "R10 single done with extra start", done_cnt, 1);
        chk(hold_viol == 0, "R9 stalled byte held", hold_viol, 0);
        bp_mode = 1'b0;
    endtask

    task automatic t_pack_b;
        logic [7:0] e [$];
        mem[8] = 16'h0000; mem[9] = 16'hFFE5;
        run(16'd40, 1'b0);
        e = '{"0","0","0","0","F","F","-","0","E","5",8'h00};
        cmp_bytes("R4 packed extremes", e);
    endtask

    task automatic t_pack_nospace;
        mem[8] = 16'h1234; mem[9] = 16'h5678;
        run(16'd10, 1'b0);
        chk(last_st == 2'd3, "R5 packed no space", last_st, 3);
        chk(got.size() == 0, "R5 no bytes", got.size(), 0);
    endtask

    task automatic t_ptr;
        logic [7:0] e [$];
        mem[8] = 16'hFAFA; mem[9] = 16'h0020;
        mem[32] = 16'd4; mem[33] = 16'h4142; mem[34] = 16'h4344; mem[35] = 16'h4546;
        bp_mode = 1'b1;
        run(16'd7, 1'b0);
        bp_mode = 1'b0;
        e = '{8'h41, 8'h42, 8'h43, 8'h44, 8'h45, 8'h46, 8'h00};
        cmp_bytes("R8 pointer stream", e);
        chk(last_st == 2'd0, "R8 pointer ok", last_st, 0);
        chk(addrs.size() == 6 && addrs[2] == 16'h20 && addrs[5] == 16'h23,
            "R6 R8 read addresses", addrs.size(), 6);
        chk(hold_viol == 0, "R9 pointer hold", hold_viol, 0);
    endtask

    task automatic t_ptr_nospace;
        run(16'd6, 1'b0);
        chk(last_st == 2'd3, "R7 pointer no space", last_st, 3);
        chk(got.size() == 0, "R7 no bytes", got.size(), 0);
    endtask

    task automatic t_ptr_len1;
        logic [7:0] e [$];
        mem[32] = 16'd1;
        run(16'd1, 1'b0);
        e = '{8'h00};
        cmp_bytes("R8 length one null only", e);
        chk(last_st == 2'd0, "R8 length one ok", last_st, 0);
    endtask

    task automatic t_badlen;
        mem[32] = 16'd0;
        run(16'd100, 1'b0);
        chk(last_st == 2'd2 && got.size() == 0, "R6 zero length", last_st, 2);
        mem[32] = 16'hFFFF;
        run(16'hFFFF, 1'b0);
        chk(last_st == 2'd2 && got.size() == 0, "R6 all-ones length", last_st, 2);
    endtask

    task automatic t_errs;
        err_en = 1'b1; err_addr = 16'h9;
        run(16'd64, 1'b0);
        chk(last_st == 2'd1 && got.size() == 0, "R2 header error", last_st, 1);
        mem[32] = 16'd4; err_addr = 16'h22;
        run(16'd64, 1'b0);
        chk(last_st == 2'd1, "R2 string word error", last_st, 1);
        chk(got.size() == 2, "R2 bytes before error", got.size(), 2);
        err_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pack_a();
        t_pack_b();
        t_pack_nospace();
        t_ptr();
        t_ptr_nospace();
        t_ptr_len1();
        t_badlen();
        t_errs();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule